// File: doc/BRIEF.md
# UART Receive Character Buffer

This block stands between the serial-to-parallel receive shifter of a UART and the processor's read port. When the shifter finishes a character, the block takes it into a one-character holding stage. From there the character moves into a two-entry first-in first-out store as soon as a slot is free. Software sees the oldest stored character on a read-only data output and removes it with a read strobe. Two status flags report whether the store holds at least one character and whether it holds two.

A buffer-full interrupt asserts when the store's occupancy reaches a threshold chosen by one control bit. An overrun is recorded in a sticky flag when all of the following hold: the store is full, the holding stage also has a finished character, and the shifter reports the start of another character in a cycle with no read. Characters are taken in either 8-bit or 7-bit form. In 7-bit form the top bit is cleared as the character is captured.

Top module: `uart_rxbuf`

## Requirements
- R1: Out of reset, rd_data is 0x00 and rdry, rd2b, irq and ovr are all 0.
- R2: Characters are returned in arrival order: rd_data shows the oldest stored character, and a rd_strobe removes it so that the next oldest appears on the following cycle.
- R3: rdry is 1 exactly when the store holds one or two characters.
- R4: rd2b is 1 exactly when the store holds two characters.
- R5: With thr_two = 0, irq is 1 whenever the store holds at least one character. With thr_two = 1, irq is 1 only when it holds two.
- R6: When mode7 is 1 at the cycle a character is captured, bit 7 of the stored character is 0. When mode7 is 0, all 8 bits are kept. In both modes rx_char[i] appears at rd_data[i], with bit 0 being the first serial bit.
- R7: A character captured by rx_done at clock edge N is visible on rd_data and in the flags after edge N+1 when the store has room. If the store is full, the character waits in the holding stage and enters the store at the same edge that a rd_strobe removes an entry, so rd2b stays 1.
- R8: ovr becomes 1 one cycle after a cycle in which the store is full, the holding stage is occupied, rx_start is 1 and rd_strobe is 0. A rd_strobe in the same cycle as rx_start prevents the overrun.
- R9: ovr stays 1 until a cycle with ovr_clr = 1. If a set condition and ovr_clr fall in the same cycle, ovr is 1 afterwards.
- R10: A character that completes while the holding stage is occupied and cannot move into the store is discarded. The held character and the stored characters are kept.
- R11: A rd_strobe while the store is empty changes nothing: rd_data stays 0x00, the flags stay 0, and the next character is stored as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 1 | Shifter finished a character this cycle |
| rx_char | input | 8 | Finished character, bit 0 = first serial bit |
| rx_start | input | 1 | Shifter detected the start of the next character |
| rd_strobe | input | 1 | Software read of the oldest character |
| mode7 | input | 1 | 1 = 7-bit characters, 0 = 8-bit |
| thr_two | input | 1 | Interrupt threshold: 0 = one entry, 1 = two entries |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| rd_data | output | 8 | Oldest stored character, 0x00 when empty |
| rdry | output | 1 | Store holds at least one character |
| rd2b | output | 1 | Store holds two characters |
| irq | output | 1 | Buffer-full interrupt at the chosen threshold |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Two pairs of functions can fall in the same cycle and are driven on purpose. The first pair is a software read and the start of a new character while the store is full and the holding stage is occupied. The bench raises rd_strobe and rx_start on the same clock. It then expects ovr to stay 0, the held character to slide into the freed slot, and the whole sequence to drain in order. The second pair is an overrun set condition and a write-one clear arriving together. For that case the bench expects ovr to read 1 afterwards, and the clear to work only when applied alone.

// File: rtl/uart_rxbuf_pkg.sv
// Package: shared character type and the 7-bit capture mask for the
// receive buffer. Assumes characters are at most 8 bits wide.
package uart_rxbuf_pkg;

    localparam int RXB_CHAR_W = 8;

    typedef logic [RXB_CHAR_W-1:0] rxb_char_t;

    // Clears the top bit when the line carries 7-bit characters.
    function automatic rxb_char_t rxb_mask(input rxb_char_t c, input logic seven);
        rxb_char_t r;
        r = c;
        if (seven) r[RXB_CHAR_W-1] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/uart_rxbuf_hold.sv
// Holding stage: keeps one finished character from the shifter until the
// store can accept it. A character arriving while the stage is occupied
// and not draining is dropped (drop pulses). Assumes drain is asserted only
// while vld is 1.
module uart_rxbuf_hold
    import uart_rxbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap,
    input  rxb_char_t cap_char,
    input  logic      seven,
    input  logic      drain,
    output logic      vld,
    output rxb_char_t data,
    output logic      drop
);

    logic load;

    // Decide whether an arriving character may enter the stage.
    always_comb begin
        load = cap && (!vld || drain);
        drop = cap && vld && !drain;
    end

    // Hold register: load, hand off, or keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            data <= rxb_mask(cap_char, seven);
        end else if (drain) begin
            vld  <= 1'b0;
        end
    end

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop) |=> (vld && $stable(data)));

    // R7
    drain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> vld);

endmodule

// File: rtl/uart_rxbuf_fifo.sv
// Character store: DEPTH-entry first-in first-out with read and write
// pointers and an occupancy count. The head entry is shown combinationally.
// Assumes the caller pushes only when count < DEPTH or a pop is accepted in
// the same cycle. A pop on an empty store is ignored.
module uart_rxbuf_fifo
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  rxb_char_t                     din,
    input  logic                          pop,
    output rxb_char_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]    count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    rxb_char_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic            pop_ok;

    // A pop counts only when something is stored.
    always_comb pop_ok = pop && (count != '0);

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            case ({push, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write, one generate slot per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (push && wr_ptr == PW'(i))   mem[i] <= din;
        end
    end

    // Oldest entry on the output.
    always_comb head = mem[rd_ptr];

    // R4
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((count < CW'(DEPTH)) || pop));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));

endmodule

// File: rtl/uart_rxbuf_ovr.sv
// Overrun detector: sets a sticky flag when the store is full, the holding
// stage is occupied and a new character starts with no read in that cycle.
// A write-one clear drops the flag; a set in the same cycle wins.
module uart_rxbuf_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic hold_vld,
    input  logic rx_start,
    input  logic rd_strobe,
    input  logic clr,
    output logic ovr
);

    logic set;

    // Overrun condition for this cycle.
    always_comb set = full && hold_vld && rx_start && !rd_strobe;

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   ovr <= 1'b0;
        else if (set) ovr <= 1'b1;
        else if (clr) ovr <= 1'b0;
    end

    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(rx_start) && !$past(rd_strobe)));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);

endmodule

// File: rtl/uart_rxbuf.sv
// Top of the receive buffer: holding stage, character store, overrun
// detector, status flags and the buffer-full interrupt. Assumes rx_done and
// rx_start are single-cycle pulses from the shifter and rd_strobe is one
// pulse per software read.
module uart_rxbuf
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_done,
    input  logic [7:0] rx_char,
    input  logic       rx_start,
    input  logic       rd_strobe,
    input  logic       mode7,
    input  logic       thr_two,
    input  logic       ovr_clr,
    output logic [7:0] rd_data,
    output logic       rdry,
    output logic       rd2b,
    output logic       irq,
    output logic       ovr
);

    localparam int CW = $clog2(DEPTH+1);

    logic           hold_vld;
    rxb_char_t      hold_data;
    logic           hold_drop;
    logic           drain;
    logic           full;
    rxb_char_t      head;
    logic [CW-1:0]  count;

    // Hand-off: the store can take the held character when it has room or
    // a read frees a slot at this edge.
    always_comb begin
        full  = (count == CW'(DEPTH));
        drain = hold_vld && (!full || rd_strobe);
    end

    uart_rxbuf_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (rx_done),
        .cap_char (rx_char),
        .seven    (mode7),
        .drain    (drain),
        .vld      (hold_vld),
        .data     (hold_data),
        .drop     (hold_drop)
    );

    uart_rxbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (drain),
        .din   (hold_data),
        .pop   (rd_strobe),
        .head  (head),
        .count (count)
    );

    uart_rxbuf_ovr u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .full      (full),
        .hold_vld  (hold_vld),
        .rx_start  (rx_start),
        .rd_strobe (rd_strobe),
        .clr       (ovr_clr),
        .ovr       (ovr)
    );

    // Status flags, read data and the threshold interrupt.
    always_comb begin
        rdry    = (count != '0);
        rd2b    = full;
        rd_data = rdry ? head : '0;
        irq     = thr_two ? rd2b : rdry;
    end

    // R3
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd2b |-> rdry);

    // R11
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdry |-> (rd_data == 8'h00));

    // R10
    drop_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_drop |-> (hold_vld && full && !rd_strobe));

endmodule

// File: tb/uart_rxbuf_tb.sv
`timescale 1ns/1ps
module uart_rxbuf_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_done = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       rx_start = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       mode7 = 1'b0;
    logic       thr_two = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rdry, rd2b, irq, ovr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_rxbuf u_dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_char(rx_char),
        .rx_start(rx_start), .rd_strobe(rd_strobe), .mode7(mode7),
        .thr_two(thr_two), .ovr_clr(ovr_clr), .rd_data(rd_data),
        .rdry(rdry), .rd2b(rd2b), .irq(irq), .ovr(ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: one finished character; keep=1 queues it as expected output.
    task automatic send(input logic [7:0] c, input logic keep);
        rx_done = 1'b1;
        rx_char = c;
        if (keep) exp_q.push_back(mode7 ? {1'b0, c[6:0]} : c);
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    // Monitor-side compare: the oldest expected entry must be on rd_data.
    task automatic read_cmp(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        check(req, rd_data, e);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic fill3(input logic [7:0] b);
        send(b, 1'b1);
        send(b + 8'h1, 1'b1);
        send(b + 8'h2, 1'b1);
        idle(2);
    endtask

    initial begin
        idle(3);
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 flags", {rdry, rd2b, irq, ovr}, 4'b0000);
        rst_n = 1'b1;
        idle(1);

        // R7 timing, R3/R5 single entry
        send(8'h3C, 1'b1);
        check("R7 not yet stored", rdry, 1'b0);
        idle(1);
        check("R3 rdry one", rdry, 1'b1);
        check("R4 rd2b one", rd2b, 1'b0);
        check("R5 irq thr1", irq, 1'b1);
        thr_two = 1'b1;
        idle(1);
        check("R5 irq thr2 one", irq, 1'b0);
        send(8'hC3, 1'b1);
        idle(1);
        check("R4 rd2b two", rd2b, 1'b1);
        check("R5 irq thr2 two", irq, 1'b1);
        read_cmp("R2 first");
        check("R4 rd2b after read", rd2b, 1'b0);
        read_cmp("R2 second");
        check("R3 rdry empty", rdry, 1'b0);

        // R11 empty read
        rd_strobe = 1'b1;
        check("R11 empty data", rd_data, 8'h00);
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R11 flags", {rdry, rd2b, ovr}, 3'b000);
        send(8'h5A, 1'b1);
        idle(1);
        check("R11 single entry", {rdry, rd2b}, 2'b10);
        read_cmp("R11 data");

        // R6 modes and bit positions
        mode7 = 1'b1;
        send(8'hFF, 1'b1);
        mode7 = 1'b0;
        send(8'hA5, 1'b1);
        idle(1);
        read_cmp("R6 seven bit");
        read_cmp("R6 eight bit");

        // R8 overrun, R10 discard, R9 sticky/clear, R7 slide-in
        fill3(8'h10);
        check("R7 full with hold", {rd2b, ovr}, 2'b10);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        check("R8 ovr set", ovr, 1'b1);
        send(8'h77, 1'b0);
        idle(2);
        check("R9 sticky", ovr, 1'b1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R9 cleared", ovr, 1'b0);
        read_cmp("R10 kept oldest");
        check("R7 slide keeps rd2b", rd2b, 1'b1);
        read_cmp("R10 kept second");
        read_cmp("R10 kept held");
        check("R10 dropped char gone", rdry, 1'b0);

        // R8 read in same cycle as start: no overrun
        fill3(8'h40);
        check("R8 precondition", rd2b, 1'b1);
        begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check("R8 read data", rd_data, e);
            rx_start  = 1'b1;
            rd_strobe = 1'b1;
            @(negedge clk);
            rx_start  = 1'b0;
            rd_strobe = 1'b0;
        end
        check("R8 no ovr with read", ovr, 1'b0);
        read_cmp("R8 drain a");
        read_cmp("R8 drain b");

        // R9 set and clear together: set wins
        fill3(8'h60);
        rx_start = 1'b1;
        ovr_clr  = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        ovr_clr  = 1'b0;
        check("R9 set wins", ovr, 1'b1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R9 clear alone", ovr, 1'b0);
        read_cmp("R2 drain a");
        read_cmp("R2 drain b");
        read_cmp("R2 drain c");
        check("R3 final empty", {rdry, irq}, 2'b00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule